// File: doc/BRIEF.md
# Montgomery Modular Multiplier

The block computes R = A·B·2^-K mod N for K-bit operands held as NW words of W bits each (K = NW·W). Software or a neighbouring engine loads the modulus N, its precomputed reduction coefficient NC = -N^-1 mod 2^K, and the operands A and B through a word-addressed write port. It then pulses `start`. The block forms the double-length product AB and the low-half product Q = AB·NC. It then forms the double-length product QN = Q·N. Every word product goes through one shared multiply-accumulate cell, one word pair per cycle.

A final word-serial pass runs over all 2·NW words, least significant word first. In each word step it adds AB and QN with a 1-bit carry. In the same step it subtracts N, aligned to the upper half, from that sum with a 1-bit borrow. The final carry and borrow then pick either the sum or the difference. Only the upper NW words of the chosen value are kept, which gives the shift right by K.

In reduce-only mode A is taken as a full 2·NW-word value and used directly as AB. The first multiplication is skipped, and B plays no part.

Top module: `mont_mul`

## Requirements
- R1: With `reduceOnly` low, odd N and A, B < N, `result` equals A·B·2^-K mod N when `done` is high. A is read from A words 0..NW-1. Word select codes on `wrSel` are: 0 = A (addresses 0..2·NW-1), 1 = B, 2 = N, 3 = NC (addresses 0..NW-1). Word address 0 is the least significant word.
- R2: With `reduceOnly` high at `start`, the 2·NW words of A form a value X < N·2^K, and `result` equals X·2^-K mod N. The contents of B have no effect on the result.
- R3: `busy` is high from the cycle after an accepted `start` until `done`. `done` is high for exactly one cycle, in which `busy` is already low and `result` already holds the new value.
- R4: While `busy` is high, `start` and operand writes are ignored. The running operation completes with its original operands and signals `done` only once. A later operation that reloads only A and B still uses the N and NC loaded before.
- R5: `result` holds its value after `done` until the next operation finishes.
- R6: After reset, `busy` and `done` are low and `result` is zero.
- R7: `result` is always fully reduced below N. This includes a zero operand, which gives zero, and maximal operands A = B = N-1.
- R8: Carry and borrow of the final pass start from zero in every operation, so back-to-back operations give results independent of the previous one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Operand word write strobe |
| wrSel | input | 2 | Operand select: 0 A, 1 B, 2 N, 3 NC |
| wrAddr | input | $clog2(2·NW) | Word address within the selected operand |
| wrData | input | W | Word to write |
| start | input | 1 | Begin an operation (ignored while busy) |
| reduceOnly | input | 1 | Sampled at start: treat A as the double-length product |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | NW·W | Result R, word 0 in the low bits |

## Verification
Small operands separate a correct word-product chain from one with an off-by-one in the carry column. Operands near the modulus and A = B = N-1 drive the sum above N·2^K, so they exercise the subtract branch of the final select. A zero operand and A = B = 1 exercise the branch that keeps the sum. Reduce-only runs use a garbage B to show that the first multiply is really bypassed. A start and a modulus write issued mid-operation, followed by a run that reloads only A and B, show at the result that the operands stayed locked.

// File: rtl/mont_mul_pkg.sv
package mont_mul_pkg;

  typedef enum logic [1:0] {
    PH_AB = 2'd0,
    PH_Q  = 2'd1,
    PH_QN = 2'd2
  } phase_t;

  // strobes from sequencer to datapath
  typedef struct packed {
    logic   load;       // operation accepted this cycle
    logic   mulEn;      // one multiply-accumulate step
    phase_t phase;      // which product is being built
    logic   rowFirst;   // row 0: accumulator reads as zero
    logic   colFirst;   // column 0: MAC carry reads as zero
    logic   carryStep;  // extra column storing the row carry
    logic   addEn;      // one word of the add/subtract pass
    logic   finish;     // select and register the result
  } strobe_t;

endpackage

// File: rtl/mont_mul_ctrl.sv
module mont_mul_ctrl
  import mont_mul_pkg::*;
#(
  parameter int NW = 4,
  localparam int QW = $clog2(NW),
  localparam int IW = $clog2(NW + 1),
  localparam int KW = $clog2(2 * NW)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          start,
  input  logic          reduceOnly,
  output strobe_t       st,
  output logic [QW-1:0] rowI,
  output logic [IW-1:0] colJ,
  output logic [KW-1:0] wordK,
  output logic          busy,
  output logic          done
);

  localparam logic [QW-1:0] LAST_ROW  = QW'(NW - 1);
  localparam logic [IW-1:0] CARRY_COL = IW'(NW);
  localparam logic [KW-1:0] LAST_WORD = KW'(2 * NW - 1);

  typedef enum logic [1:0] {S_IDLE, S_MUL, S_ADD, S_FIN} state_t;
  state_t state;
  phase_t phase;

  always_comb begin
    st.load      = (state == S_IDLE) && start;
    st.mulEn     = (state == S_MUL);
    st.phase     = phase;
    st.rowFirst  = (rowI == '0);
    st.colFirst  = (colJ == '0);
    st.carryStep = (colJ == CARRY_COL);
    st.addEn     = (state == S_ADD);
    st.finish    = (state == S_FIN);
  end

  assign busy = (state != S_IDLE);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= S_IDLE;
      phase <= PH_AB;
      rowI  <= '0;
      colJ  <= '0;
      wordK <= '0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        S_IDLE: if (start) begin
          phase <= reduceOnly ? PH_Q : PH_AB;
          rowI  <= '0;
          colJ  <= '0;
          state <= S_MUL;
        end
        S_MUL: begin
          if (colJ == CARRY_COL) begin
            colJ <= '0;
            if (rowI == LAST_ROW) begin
              rowI <= '0;
              if (phase == PH_QN) begin
                wordK <= '0;
                state <= S_ADD;
              end else begin
                phase <= phase_t'(phase + 2'd1);
              end
            end else begin
              rowI <= rowI + 1'b1;
            end
          end else begin
            colJ <= colJ + 1'b1;
          end
        end
        S_ADD: begin
          if (wordK == LAST_WORD) state <= S_FIN;
          else wordK <= wordK + 1'b1;
        end
        default: begin
          state <= S_IDLE;
          done  <= 1'b1;
        end
      endcase
    end
  end

  assert_done_single_R3: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  assert_done_idle_R3: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);
  assert_busy_held_R4: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !st.finish) |=> busy);

endmodule

// File: rtl/mont_mul_dp.sv
module mont_mul_dp
  import mont_mul_pkg::*;
#(
  parameter int W  = 8,
  parameter int NW = 4,
  localparam int QW = $clog2(NW),
  localparam int IW = $clog2(NW + 1),
  localparam int KW = $clog2(2 * NW)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  strobe_t                st,
  input  logic [QW-1:0]          rowI,
  input  logic [IW-1:0]          colJ,
  input  logic [KW-1:0]          wordK,
  input  logic                   busy,
  input  logic                   reduceOnly,
  input  logic                   wrEn,
  input  logic [1:0]             wrSel,
  input  logic [KW-1:0]          wrAddr,
  input  logic [W-1:0]           wrData,
  output logic [NW-1:0][W-1:0]   result
);

  localparam logic [KW-1:0] NW_K = KW'(NW);

  logic [2*NW-1:0][W-1:0] aMem, abMem, qnMem;
  logic [NW-1:0][W-1:0]   bMem, nMem, ncMem, qMem, sHi, snHi;
  logic                   modeReg, cS, bS;
  logic [W-1:0]           macCarry;

  // multiply-accumulate operand selection
  logic [KW-1:0]  idx;
  logic [W-1:0]   xW, yW, accIn, cIn, abY;
  logic [2*W-1:0] macOut;

  always_comb begin
    idx = KW'(rowI) + KW'(colJ);
    abY = modeReg ? aMem[KW'(colJ)] : abMem[KW'(colJ)];
    unique case (st.phase)
      PH_AB:   xW = aMem[KW'(rowI)];
      PH_Q:    xW = ncMem[rowI];
      default: xW = qMem[rowI];
    endcase
    if (st.carryStep) yW = '0;
    else begin
      unique case (st.phase)
        PH_AB:   yW = bMem[colJ[QW-1:0]];
        PH_Q:    yW = abY;
        default: yW = nMem[colJ[QW-1:0]];
      endcase
    end
    if (st.rowFirst || st.carryStep) accIn = '0;
    else begin
      unique case (st.phase)
        PH_AB:   accIn = abMem[idx];
        PH_Q:    accIn = (idx < NW_K) ? qMem[idx[QW-1:0]] : '0;
        default: accIn = qnMem[idx];
      endcase
    end
    cIn    = st.colFirst ? '0 : macCarry;
    macOut = (2*W)'(accIn) + (2*W)'(cIn) + (2*W)'(xW) * (2*W)'(yW);
  end

  // combined add / subtract word step
  logic [QW-1:0] hiK;
  logic [W-1:0]  abK, nSub;
  logic [W:0]    sumW, diffW;

  always_comb begin
    hiK   = QW'(wordK - NW_K);
    abK   = modeReg ? aMem[wordK] : abMem[wordK];
    nSub  = (wordK >= NW_K) ? nMem[hiK] : '0;
    sumW  = (W+1)'(abK) + (W+1)'(qnMem[wordK]) + (W+1)'(cS);
    diffW = (W+1)'(sumW[W-1:0]) - (W+1)'(nSub) - (W+1)'(bS);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      aMem <= '0; abMem <= '0; qnMem <= '0;
      bMem <= '0; nMem <= '0; ncMem <= '0; qMem <= '0;
      sHi <= '0; snHi <= '0; result <= '0;
      modeReg <= 1'b0; cS <= 1'b0; bS <= 1'b0; macCarry <= '0;
    end else begin
      if (wrEn && !busy) begin
        unique case (wrSel)
          2'd0: aMem[wrAddr] <= wrData;
          2'd1: if (wrAddr < NW_K) bMem[wrAddr[QW-1:0]] <= wrData;
          2'd2: if (wrAddr < NW_K) nMem[wrAddr[QW-1:0]] <= wrData;
          default: if (wrAddr < NW_K) ncMem[wrAddr[QW-1:0]] <= wrData;
        endcase
      end
      if (st.load) begin
        modeReg <= reduceOnly;
        cS <= 1'b0;
        bS <= 1'b0;
      end
      if (st.mulEn) begin
        macCarry <= macOut[2*W-1:W];
        unique case (st.phase)
          PH_AB:   abMem[idx] <= macOut[W-1:0];
          PH_Q:    if (idx < NW_K) qMem[idx[QW-1:0]] <= macOut[W-1:0];
          default: qnMem[idx] <= macOut[W-1:0];
        endcase
      end
      if (st.addEn) begin
        cS <= sumW[W];
        bS <= diffW[W];
        if (wordK >= NW_K) begin
          sHi[hiK]  <= sumW[W-1:0];
          snHi[hiK] <= diffW[W-1:0];
        end
      end
      if (st.finish) result <= (bS && !cS) ? sHi : snHi;
    end
  end

  assert_flags_clear_R8: assert property (@(posedge clk) disable iff (!rstN)
    (st.addEn && wordK == '0) |-> (!cS && !bS));
  assert_fully_reduced_R7: assert property (@(posedge clk) disable iff (!rstN)
    st.finish |=> (result < nMem));
  assert_operands_locked_R4: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> ($stable(nMem) && $stable(ncMem) && $stable(aMem) && $stable(bMem)));
  assert_result_held_R5: assert property (@(posedge clk) disable iff (!rstN)
    !st.finish |=> $stable(result));

endmodule

// File: rtl/mont_mul.sv
module mont_mul
  import mont_mul_pkg::*;
#(
  parameter int W  = 8,
  parameter int NW = 4,
  localparam int QW = $clog2(NW),
  localparam int IW = $clog2(NW + 1),
  localparam int KW = $clog2(2 * NW)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            wrEn,
  input  logic [1:0]      wrSel,
  input  logic [KW-1:0]   wrAddr,
  input  logic [W-1:0]    wrData,
  input  logic            start,
  input  logic            reduceOnly,
  output logic            busy,
  output logic            done,
  output logic [NW*W-1:0] result
);

  strobe_t              st;
  logic [QW-1:0]        rowI;
  logic [IW-1:0]        colJ;
  logic [KW-1:0]        wordK;
  logic [NW-1:0][W-1:0] resWords;

  mont_mul_ctrl #(.NW(NW)) ctrl (
    .clk(clk), .rstN(rstN), .start(start), .reduceOnly(reduceOnly),
    .st(st), .rowI(rowI), .colJ(colJ), .wordK(wordK),
    .busy(busy), .done(done)
  );

  mont_mul_dp #(.W(W), .NW(NW)) dp (
    .clk(clk), .rstN(rstN), .st(st), .rowI(rowI), .colJ(colJ), .wordK(wordK),
    .busy(busy), .reduceOnly(reduceOnly), .wrEn(wrEn), .wrSel(wrSel),
    .wrAddr(wrAddr), .wrData(wrData), .result(resWords)
  );

  assign result = resWords;

endmodule

// File: tb/mont_mul_test.sv
`timescale 1ns/1ps
module mont_mul_test;

  localparam int W = 8;
  localparam int NW = 4;
  localparam int KW = $clog2(2 * NW);

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic            wrEn = 1'b0;
  logic [1:0]      wrSel = '0;
  logic [KW-1:0]   wrAddr = '0;
  logic [W-1:0]    wrData = '0;
  logic            start = 1'b0;
  logic            reduceOnly = 1'b0;
  logic            busy, done;
  logic [NW*W-1:0] result;

  int checks = 0;
  int fails = 0;

  always #4 clk = ~clk;

  mont_mul #(.W(W), .NW(NW)) uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel), .wrAddr(wrAddr),
    .wrData(wrData), .start(start), .reduceOnly(reduceOnly),
    .busy(busy), .done(done), .result(result)
  );

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog: run did not finish, actual running expected stopped");
    summary();
    $finish;
  end

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // bit-serial reference: x * 2^-32 mod n
  function automatic logic [31:0] montRef(input logic [63:0] x, input logic [31:0] n);
    logic [64:0] v = {1'b0, x};
    for (int k = 0; k < 32; k++) begin
      if (v[0]) v = v + {33'd0, n};
      v = v >> 1;
    end
    if (v >= {33'd0, n}) v = v - {33'd0, n};
    return v[31:0];
  endfunction

  function automatic logic [31:0] calcNc(input logic [31:0] n);
    logic [31:0] inv = n;
    for (int k = 0; k < 5; k++) inv = inv * (32'd2 - n * inv);
    return -inv;
  endfunction

  task automatic writeWord(input logic [1:0] sel, input int addr, input logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrSel = sel; wrAddr = KW'(addr); wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic loadAB(input logic [63:0] a, input logic [31:0] b);
    for (int w = 0; w < 8; w++) writeWord(2'd0, w, a[w*8 +: 8]);
    for (int w = 0; w < 4; w++) writeWord(2'd1, w, b[w*8 +: 8]);
  endtask

  task automatic loadN(input logic [31:0] n);
    logic [31:0] nc = calcNc(n);
    for (int w = 0; w < 4; w++) writeWord(2'd2, w, n[w*8 +: 8]);
    for (int w = 0; w < 4; w++) writeWord(2'd3, w, nc[w*8 +: 8]);
  endtask

  task automatic pulseStart(input logic red);
    @(negedge clk);
    start = 1'b1; reduceOnly = red;
    @(negedge clk);
    start = 1'b0; reduceOnly = 1'b0;
    check("R3 busy after start", {63'd0, busy}, 64'd1);
  endtask

  task automatic waitDone(output logic [31:0] res);
    int n = 0;
    while (n < 1000) begin
      @(posedge clk); #1;
      if (done) break;
      n++;
    end
    check("R3 done seen", {63'd0, done}, 64'd1);
    check("R3 not busy with done", {63'd0, busy}, 64'd0);
    res = result;
    @(posedge clk); #1;
    check("R3 done single cycle", {63'd0, done}, 64'd0);
  endtask

  task automatic runOp(input string tag, input logic [63:0] a, input logic [31:0] b,
                       input logic [31:0] n, input logic red);
    logic [31:0] res;
    loadN(n);
    loadAB(a, b);
    pulseStart(red);
    waitDone(res);
    check(tag, {32'd0, res}, {32'd0, red ? montRef(a, n) : montRef(a * b, n)});
    check("R7 below modulus", {63'd0, res < n}, 64'd1);
  endtask

  task automatic testReset();
    check("R6 busy at reset", {63'd0, busy}, 64'd0);
    check("R6 done at reset", {63'd0, done}, 64'd0);
    check("R6 result at reset", {32'd0, result}, 64'd0);
  endtask

  task automatic testNormal();
    runOp("R1 small", 64'd5, 32'd7, 32'hFFFF_FFFB, 1'b0);
    runOp("R1 mixed", 64'h1234_5678, 32'h0FED_CBA9, 32'hC3A5_F00D, 1'b0);
    runOp("R1 unit", 64'd1, 32'd1, 32'h8000_0001, 1'b0);
    runOp("R1 small modulus", 64'h0000_00C1, 32'h0000_00FE, 32'h0000_0101, 1'b0);
  endtask

  task automatic testBounds();
    runOp("R7 zero operand", 64'd0, 32'h7777_7777, 32'hC3A5_F00D, 1'b0);
    runOp("R7 max operands", 64'hFFFF_FFFE, 32'hFFFF_FFFE, 32'hFFFF_FFFF, 1'b0);
    runOp("R7 near modulus", 64'hC3A5_F00C, 32'hC3A5_F00B, 32'hC3A5_F00D, 1'b0);
  endtask

  task automatic testReduce();
    runOp("R2 reduce", 64'h1234_5678_9ABC_DEF0, 32'hDEAD_BEEF, 32'hF123_4567, 1'b1);
    runOp("R2 reduce other B", 64'h1234_5678_9ABC_DEF0, 32'h0000_0001, 32'hF123_4567, 1'b1);
    runOp("R2 reduce top", 64'hF123_4566_FFFF_FFFF, 32'h5555_5555, 32'hF123_4567, 1'b1);
  endtask

  task automatic testBusyIgnore();
    logic [31:0] res;
    int extra = 0;
    loadN(32'hC3A5_F00D);
    loadAB(64'h2468_ACE1, 32'h1357_9BDF);
    pulseStart(1'b0);
    // mid-operation: corrupt modulus and restart in reduce mode
    @(negedge clk);
    wrEn = 1'b1; wrSel = 2'd2; wrAddr = '0; wrData = 8'h00;
    start = 1'b1; reduceOnly = 1'b1;
    @(negedge clk);
    wrEn = 1'b0; start = 1'b0; reduceOnly = 1'b0;
    waitDone(res);
    check("R4 result unaffected", {32'd0, res}, {32'd0, montRef(64'h2468_ACE1 * 64'h1357_9BDF, 32'hC3A5_F00D)});
    for (int c = 0; c < 100; c++) begin
      @(posedge clk); #1;
      if (done) extra++;
    end
    check("R4 single done", extra, 64'd0);
    check("R5 result held", {32'd0, result}, {32'd0, res});
    loadAB(64'h0000_0003, 32'h0000_0009);
    pulseStart(1'b0);
    waitDone(res);
    check("R4 modulus kept", {32'd0, res}, {32'd0, montRef(64'd27, 32'hC3A5_F00D)});
  endtask

  task automatic testBackToBack();
    logic [31:0] r1, r2;
    loadN(32'hFFFF_FFFF);
    loadAB(64'hFFFF_FFFE, 32'hFFFF_FFFE);
    pulseStart(1'b0);
    waitDone(r1);
    loadAB(64'd2, 32'd3);
    pulseStart(1'b0);
    waitDone(r2);
    check("R8 first", {32'd0, r1}, {32'd0, montRef(64'hFFFF_FFFE * 64'hFFFF_FFFE, 32'hFFFF_FFFF)});
    check("R8 second", {32'd0, r2}, {32'd0, montRef(64'd6, 32'hFFFF_FFFF)});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testNormal();
    testBounds();
    testReduce();
    testBusyIgnore();
    testBackToBack();
    summary();
    $finish;
  end

endmodule